// File: doc/BRIEF.md
# Flow-controlled host UART

This block is a full-duplex asynchronous serial port for a host transport link. Each character is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit; there is no parity. A shared 16x oversampling tick sets the bit rate. The tick divider comes out of reset at the value for 57.6 kbit/s and can be rewritten to any rate from 300 baud to 921.6 kbaud.

Bytes to send go into a 128-entry transmit queue. Received bytes, each tagged with a framing-error flag, come out of a 128-entry receive queue that shows its head byte ahead of the pop. Two level interrupts tell the host when the receive queue holds enough bytes and when the transmit queue has enough free space. The handshake works in both directions. A new transmit character starts only while the peer's clear-to-send input is high. The request-to-send output falls while the receive queue still has room for every byte the peer may send during a 3 ms flow-off window at the margin rate.

Top module: `hostlink_uart`

## Requirements
- R1: Transmit framing: the txd line idles high. A character is a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. Each bit lasts 16 ticks of the baud generator.
- R2: The receiver samples each data bit at mid-bit and assembles the bits LSB first. Bytes appear on rx_data/rx_valid in arrival order. A one-cycle rx_pop removes the head byte.
- R3: After reset the tick divider is CLK_HZ/(16*DEF_BAUD), which is 16 by default, so one bit lasts 256 clocks. A div_wr pulse loads div_val, and one bit then lasts 16*div_val clocks. A div_val of 0 is treated as 1.
- R4: Each queue holds 128 bytes. tx_full is 1 at 128 entries. A push into a full transmit queue is ignored.
- R5: No new character starts while the synchronized cts is 0. A character already in progress when cts falls completes normally.
- R6: rts is 1 while the receive queue's free space exceeds RTS_MARGIN (18 by default, which is 3 ms at 57.6 kbit/s rounded up). rts is 0 once the free space is 18 or fewer, which means 110 or more stored bytes.
- R7: rx_irq is 1 exactly when the receive count is greater than or equal to rx_thresh, for rx_thresh from 1 to 127.
- R8: tx_irq is 1 exactly when the transmit free space (128 minus the count) is greater than or equal to tx_thresh, for tx_thresh from 1 to 128.
- R9: The receiver rejects a start bit that is no longer low at its midpoint. Such a low pulse produces no byte.
- R10: A 0 sampled at the stop-bit position stores the byte with rx_ferr = 1. The receiver then waits for the line to return high before it looks for the next start bit.
- R11: txd is 0 while rst_n is low. After reset, txd idles at 1, rts is 1 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Load pulse for the tick divider |
| div_val | input | 16 | New divider value, in clocks per tick |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue holds 128 bytes |
| tx_thresh | input | 8 | Transmit free-space interrupt threshold |
| tx_irq | output | 1 | Transmit free space is at or above the threshold |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_valid | output | 1 | Receive queue not empty |
| rx_data | output | 8 | Head byte of the receive queue |
| rx_ferr | output | 1 | Framing-error flag of the head byte |
| rx_thresh | input | 8 | Receive count interrupt threshold |
| rx_irq | output | 1 | Receive count is at or above the threshold |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Peer allows this side to send (1 = allowed) |
| rts | output | 1 | This side allows the peer to send (1 = allowed) |

## Verification
The hardest state to reach is the receive queue sitting right at the request-to-send margin. Getting there takes 110 full serial characters with nothing popped, and the bench checks the pin just before and just after the crossing and again after one pop. A clear-to-send drop in the middle of a character is the other awkward case. The bench drops the line 40 clocks into a character while a second byte waits in the queue. It then checks that the first character finishes intact and that the line stays idle until clear-to-send returns.

// File: rtl/hlu_pkg.sv
// Shared constants and types for the host-link UART.
package hlu_pkg;
    localparam int OSR = 16;            // ticks per serial bit
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_t;
endpackage

// File: rtl/hlu_baud.sv
// Oversampling tick generator. Emits a one-cycle tick every div_q clocks.
// Assumes div_val is written only from the host side; 0 is promoted to 1.
module hlu_baud #(
    parameter int DIV_W   = 16,
    parameter int DEF_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div_q - 1'b1);

    // Divider register and free-running tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DEF_DIV);
            cnt_q <= '0;
        end else if (div_wr) begin
            div_q <= (div_val == '0) ? DIV_W'(1) : div_val;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hlu_fifo.sv
// Show-ahead synchronous FIFO. Assumes DEPTH is a power of two.
// Pushes while full and pops while empty are dropped.
module hlu_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hlu_tx.sv
// Serial transmitter. Starts a character on a tick when data is queued and
// cts_ok is high; once started the character always runs to its stop bit.
// txd is registered and held low during reset.
module hlu_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cts_ok,
    input  logic       have_data,
    input  logic [7:0] data,
    output logic       take,
    output logic       busy,
    output logic       txd
);
    localparam int SW = $clog2(hlu_pkg::OSR);
    localparam int FB = hlu_pkg::DATA_BITS + 2;
    localparam int BW = $clog2(FB);

    logic [FB-1:0] frame;
    logic [SW-1:0] sub;
    logic [BW-1:0] bitn;

    assign take = tick && !busy && have_data && cts_ok;

    // Frame sequencing and line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            sub   <= '0;
            bitn  <= '0;
            txd   <= 1'b0;
        end else begin
            txd <= busy ? frame[0] : 1'b1;
            if (take) begin
                busy  <= 1'b1;
                frame <= {1'b1, data, 1'b0};
                sub   <= '0;
                bitn  <= '0;
            end else if (busy && tick) begin
                if (sub == SW'(hlu_pkg::OSR - 1)) begin
                    sub <= '0;
                    if (bitn == BW'(FB - 1)) begin
                        busy <= 1'b0;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        frame <= {1'b1, frame[FB-1:1]};
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hlu_rx.sv
// Serial receiver with 16x oversampling. Expects an already synchronized
// line. Confirms the start bit at its midpoint, samples data mid-bit and
// flags a low stop bit. After such a flag it waits for the line to go high.
module hlu_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    output logic       push,
    output logic [7:0] data,
    output logic       ferr
);
    import hlu_pkg::*;
    localparam int SW = $clog2(OSR);

    rx_state_t     state;
    logic [SW-1:0] sub;
    logic [2:0]    bitn;

    // Receive state machine and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            data  <= '0;
            ferr  <= 1'b0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: if (!rx_s) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                    RX_START: if (sub == SW'(OSR / 2 - 1)) begin
                        sub   <= '0;
                        bitn  <= '0;
                        state <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_DATA: if (sub == SW'(OSR - 1)) begin
                        sub  <= '0;
                        data <= {rx_s, data[7:1]};
                        if (bitn == 3'd7) state <= RX_STOP;
                        else              bitn  <= bitn + 1'b1;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_STOP: if (sub == SW'(OSR - 1)) begin
                        sub   <= '0;
                        push  <= 1'b1;
                        ferr  <= !rx_s;
                        state <= rx_s ? RX_IDLE : RX_WAITHI;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_WAITHI: if (rx_s) state <= RX_IDLE;
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/hostlink_uart.sv
// Host-link UART top: 8N1 framing, 128-byte queues, threshold interrupts,
// and RTS/CTS handshake. Inputs cts and rxd are asynchronous and are
// synchronized here. All other inputs come from the clk domain.
module hostlink_uart #(
    parameter int CLK_HZ     = 14_745_600,
    parameter int DEF_BAUD   = 57_600,
    parameter int DEPTH      = 128,
    parameter int DIV_W      = 16,
    parameter int FLOWOFF_US = 3000,
    parameter int MARGIN_BAUD = 57_600,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int DEF_DIV    = CLK_HZ / (16 * DEF_BAUD),
    localparam int RTS_MARGIN = (FLOWOFF_US * MARGIN_BAUD + 9_999_999) / 10_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    output logic             tx_full,
    input  logic [CW-1:0]    tx_thresh,
    output logic             tx_irq,
    input  logic             rx_pop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_ferr,
    input  logic [CW-1:0]    rx_thresh,
    output logic             rx_irq,
    output logic             txd,
    input  logic             rxd,
    input  logic             cts,
    output logic             rts
);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] MARGIN_C = CW'(RTS_MARGIN);

    logic          tick;
    logic [1:0]    cts_sync, rxd_sync;
    logic          cts_s, rx_s;
    logic          tx_take, tx_busy, tx_empty;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_count, rx_count;
    logic          rx_push, rx_bit_ferr, rx_empty, rx_full;
    logic [7:0]    rx_byte;
    logic [8:0]    rx_word;

    assign cts_s = cts_sync[1];
    assign rx_s  = rxd_sync[1];

    // Two-stage synchronizers for the asynchronous line inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_sync <= 2'b00;
            rxd_sync <= 2'b11;
        end else begin
            cts_sync <= {cts_sync[0], cts};
            rxd_sync <= {rxd_sync[0], rxd};
        end
    end

    hlu_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val), .tick(tick)
    );

    hlu_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_take), .rdata(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    hlu_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cts_ok(cts_s),
        .have_data(!tx_empty), .data(tx_head), .take(tx_take),
        .busy(tx_busy), .txd(txd)
    );

    hlu_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
        .push(rx_push), .data(rx_byte), .ferr(rx_bit_ferr)
    );

    hlu_fifo #(.WIDTH(9), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata({rx_bit_ferr, rx_byte}),
        .pop(rx_pop), .rdata(rx_word), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    assign rx_valid = !rx_empty;
    assign rx_data  = rx_word[7:0];
    assign rx_ferr  = rx_word[8];
    assign rx_irq   = (rx_count >= rx_thresh);
    assign tx_irq   = ((DEPTH_C - tx_count) >= tx_thresh);

    // Flow-off output: withdraw permission while enough room remains.
    always_ff @(posedge clk) begin
        if (!rst_n) rts <= 1'b1;
        else        rts <= ((DEPTH_C - rx_count) > MARGIN_C);
    end
endmodule

// File: rtl/hlu_checker.sv
// Property checker for hostlink_uart, attached by bind. It observes the
// line, handshake and queue occupancy and drives nothing.
module hlu_checker #(
    parameter int DEPTH  = 128,
    parameter int CW     = 8,
    parameter int MARGIN = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          cts_s,
    input logic          tx_take,
    input logic          tx_busy,
    input logic          rts,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    // R11: line is held low while reset is active.
    a_r11_txd_low_in_reset: assert property (@(posedge clk) !rst_n |=> !txd);

    // R5: a character is only launched with clear-to-send.
    a_r5_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> cts_s);

    // R1: an idle transmitter leaves the line high.
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |=> txd);

    // R6: flow-off once the receive queue reaches the margin.
    a_r6_rts_low_near_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= CW'(DEPTH - MARGIN)) |=> !rts);

    // R6: permission is granted while room exceeds the margin.
    a_r6_rts_high_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count < CW'(DEPTH - MARGIN)) |=> rts);

    // R4: neither queue ever exceeds its depth.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));
endmodule

bind hostlink_uart hlu_checker #(
    .DEPTH(DEPTH), .CW(CW), .MARGIN(RTS_MARGIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .cts_s(cts_s), .tx_take(tx_take),
    .tx_busy(tx_busy), .rts(rts), .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/hostlink_uart_bench.sv
module hostlink_uart_bench;
    localparam int DEF_DIV = 14_745_600 / (16 * 57_600);
    localparam int NVEC = 6;
    // {rx byte, stop bit level, expected data, expected framing flag}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h55, 1'b1, 8'h55, 1'b0},
        {8'hAA, 1'b1, 8'hAA, 1'b0},
        {8'h00, 1'b1, 8'h00, 1'b0},
        {8'hFF, 1'b1, 8'hFF, 1'b0},
        {8'h81, 1'b0, 8'h81, 1'b1},
        {8'h3C, 1'b1, 8'h3C, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic div_wr = 1'b0;
    logic [15:0] div_val = '0;
    logic tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0, rx_data;
    logic [7:0] tx_thresh = 8'd128, rx_thresh = 8'd1;
    logic tx_full, tx_irq, rx_valid, rx_ferr, rx_irq, txd, rts;
    logic rxd = 1'b1, cts = 1'b0;

    int checks = 0, fails = 0;
    int bit_t = 16;
    logic [7:0] got;
    int gerr;

    hostlink_uart u_hostlink_uart (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .tx_thresh(tx_thresh), .tx_irq(tx_irq), .rx_pop(rx_pop),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .rx_thresh(rx_thresh), .rx_irq(rx_irq), .txd(txd), .rxd(rxd),
        .cts(cts), .rts(rts)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_data = d; tx_push = 1'b1; cyc(1); tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] v);
        div_val = v; div_wr = 1'b1; cyc(1); div_wr = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stopv);
        rxd = 1'b0; cyc(bit_t);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; cyc(bit_t); end
        rxd = stopv; cyc(bit_t);
        rxd = 1'b1; cyc(bit_t);
    endtask

    // Decode one character from txd; err counts framing problems.
    task automatic get_tx(output logic [7:0] d, output int err);
        int n = 0;
        err = 0; d = '0;
        while (txd !== 1'b0 && n < 40000) begin cyc(1); n++; end
        if (n >= 40000) err++;
        cyc(bit_t / 2);
        if (txd !== 1'b0) err++;
        for (int i = 0; i < 8; i++) begin cyc(bit_t); d[i] = txd; end
        cyc(bit_t);
        if (txd !== 1'b1) err++;
    endtask

    // Cycles that txd stays low after its next falling edge.
    task automatic low_len(output int len);
        int n = 0;
        len = 0;
        while (txd !== 1'b0 && n < 40000) begin cyc(1); n++; end
        while (txd === 1'b0 && len < 40000) begin cyc(1); len++; end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int len, lows, bad, n;
        cyc(5);
        chk("R11 txd low in reset", txd, 0);
        rst_n = 1'b1;
        cyc(3);
        chk("R11 txd idle high", txd, 1);
        chk("R11 rts after reset", rts, 1);
        chk("R11 rx empty", rx_valid, 0);
        chk("R7 rx_irq empty", rx_irq, 0);
        chk("R8 tx_irq empty", tx_irq, 1);

        // R3 default rate, then a written rate, then 0 promoted to 1.
        cts = 1'b1; cyc(4);
        push_tx(8'hFF);
        low_len(len);
        chk("R3 default bit length", len, 16 * DEF_DIV);
        cyc(16 * DEF_DIV * 10);
        set_div(16'd3);
        push_tx(8'hFF);
        low_len(len);
        chk("R3 div 3 bit length", len, 48);
        cyc(48 * 10);
        set_div(16'd0);
        bit_t = 16;
        push_tx(8'hFF);
        low_len(len);
        chk("R3 div 0 as 1", len, 16);
        cyc(200);

        // Vector table: receive path (R2, R10) and transmit path (R1).
        for (int v = 0; v < NVEC; v++) begin
            send_rx(VEC[v][17:10], VEC[v][9]);
            chk("R2 rx_valid", rx_valid, 1);
            chk("R2 rx_data", rx_data, VEC[v][8:1]);
            chk("R10 rx_ferr", rx_ferr, VEC[v][0]);
            pop_rx();
            chk("R2 popped empty", rx_valid, 0);
            push_tx(VEC[v][17:10]);
            get_tx(got, gerr);
            chk("R1 tx data", got, VEC[v][17:10]);
            chk("R1 tx framing", gerr, 0);
        end

        // R5: held by cts low, then mid-character drop.
        cts = 1'b0; cyc(4);
        push_tx(8'h5A);
        lows = 0;
        for (int i = 0; i < 400; i++) begin cyc(1); if (txd !== 1'b1) lows++; end
        chk("R5 no start while cts low", lows, 0);
        chk("R8 tx_irq one queued", tx_irq, 0);
        cts = 1'b1;
        get_tx(got, gerr);
        chk("R5 released byte", got, 8'h5A);
        push_tx(8'hA5);
        push_tx(8'h3C);
        fork
            get_tx(got, gerr);
            begin cyc(40); cts = 1'b0; end
        join
        chk("R5 in-progress byte completes", got, 8'hA5);
        chk("R5 in-progress framing", gerr, 0);
        lows = 0;
        for (int i = 0; i < 400; i++) begin cyc(1); if (txd !== 1'b1) lows++; end
        chk("R5 second byte held", lows, 0);
        cts = 1'b1;
        get_tx(got, gerr);
        chk("R5 second byte after cts", got, 8'h3C);

        // R4/R8: fill the transmit queue.
        cts = 1'b0; cyc(4);
        tx_thresh = 8'd128; cyc(1);
        chk("R8 tx_irq free 128", tx_irq, 1);
        push_tx(8'd0);
        chk("R8 tx_irq free 127 thr 128", tx_irq, 0);
        tx_thresh = 8'd127; cyc(1);
        chk("R8 tx_irq free 127 thr 127", tx_irq, 1);
        for (int i = 1; i < 128; i++) push_tx(8'(i));
        chk("R4 tx_full at 128", tx_full, 1);
        chk("R8 tx_irq full", tx_irq, 0);
        push_tx(8'hEE);
        cts = 1'b1;
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            get_tx(got, gerr);
            if (got != 8'(i) || gerr != 0) bad++;
        end
        chk("R4 128 bytes in order", bad, 0);
        lows = 0;
        for (int i = 0; i < 400; i++) begin cyc(1); if (txd !== 1'b1) lows++; end
        chk("R4 push into full ignored", lows, 0);

        // R7/R6: fill the receive queue to the flow-off margin.
        rx_thresh = 8'd3;
        for (int i = 0; i < 110; i++) begin
            send_rx(8'(i), 1'b1);
            if (i == 1)   chk("R7 rx_irq count 2 thr 3", rx_irq, 0);
            if (i == 2)   chk("R7 rx_irq count 3 thr 3", rx_irq, 1);
            if (i == 108) chk("R6 rts at 109 stored", rts, 1);
            if (i == 109) chk("R6 rts at 110 stored", rts, 0);
        end
        chk("R2 head is oldest", rx_data, 0);
        pop_rx(); cyc(3);
        chk("R6 rts after one pop", rts, 1);
        n = 0;
        while (rx_valid && n < 200) begin pop_rx(); n++; end
        chk("R2 remaining count", n, 109);
        chk("R7 rx_irq drained", rx_irq, 0);

        // R9: a short low pulse is not a start bit.
        rxd = 1'b0; cyc(4); rxd = 1'b1; cyc(60);
        chk("R9 glitch rejected", rx_valid, 0);
        send_rx(8'h96, 1'b1);
        chk("R9 next byte ok", rx_data, 8'h96);
        pop_rx();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule